// File: doc/BRIEF.md
# Dual-Page Diagnostic Register Slave on a Two-Wire Bus

This block is a slave on a two-wire serial bus of the I2C kind, inside a module that reports its own health. It answers at two 7-bit device addresses. Each address opens its own 256-byte page. The first page holds identification bytes and cannot be written. The second page holds the following:

- fixed alarm and warning thresholds;
- live temperature and supply-voltage words;
- a control byte with one soft switch;
- four flag bytes;
- a scratch area that the host can write.

The host writes the byte pointer as the first data byte of a write transaction. It can then keep writing, or it can issue a repeated start and read any number of bytes. The pointer moves forward by one after every byte and wraps within the page.

Both bus lines are oversampled by the system clock through two-flop synchronizers. The data line output is open-drain: the block only ever pulls it low. A parallel sensor port loads the live words and flags in one strobe.

Each live value is a two-byte pair. When the host reads the high byte, the block latches the low byte of the same sample. The host therefore always sees a matched pair, even if the sensor port updates between the two bytes.

Top module: `diag_twowire_slave`

## Requirements
- R1: The block acknowledges the address bytes 0xA0/0xA1 (device 0x50, identification page) and 0xA2/0xA3 (device 0x51, diagnostic page). It leaves the bus released for any other device address and stays released while idle.
- R2: On the identification page, byte n for n < 128 reads (n XOR 0xA5), and bytes 128–255 read 0x00. Data writes to this page are acknowledged and change nothing, including the control byte.
- R3: Diagnostic bytes 0–55 are thresholds that read (n + 0x40). A data write to them is acknowledged but not stored.
- R4: Diagnostic bytes 56–95, 100–109, 111, 114, 115, 118–127 and 248–255 read 0x00. Writes to them have no effect.
- R5: Diagnostic bytes 128–247 store whatever the host writes, up to 8 data bytes per transaction, and read the stored values back.
- R6: A one-cycle sensor load strobe captures the temperature word into bytes 96 (high) and 97 (low), and the supply word into bytes 98 (high) and 99 (low).
- R7: Reading byte 96 or 98 latches the low byte of the same sample. A sequential read of the next byte then returns that latched value, even if a sensor load happens in between. A read of byte 97 or 99 that does not directly follow its high byte returns the current live low byte.
- R8: The first data byte of a write sets the pointer. Every later written or read byte advances it by one, and it wraps from 255 to 0.
- R9: Diagnostic byte 110 keeps only bit 6, which drives the soft disable output, and reads back as {0, bit6, 000000}.
- R10: The sensor flag word's bytes appear at diagnostic bytes 112 (bits 31:24), 113 (23:16), 116 (15:8) and 117 (7:0).
- R11: A read ends when the host does not acknowledge a byte; the block then releases the data line. The block changes its data-line drive only while the clock is low, and a stop condition always releases the line.
- R12: After reset the data line is released, the soft disable output is 0 and the live bytes read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaLowOut | output | 1 | 1 pulls the data line low; 0 releases it |
| sensorLoad | input | 1 | One-cycle strobe that captures the sensor words |
| tempWord | input | 16 | Temperature sample |
| vccWord | input | 16 | Supply voltage sample |
| flagWord | input | 32 | Alarm and warning flag bytes |
| ctrlSoftOff | output | 1 | Soft disable bit held in control byte 110 |

## Verification
The embedded assertions check the bus-level rules on every cycle:

- the line is released while idle and after a stop;
- the drive changes only while the clock is low;
- the pointer is loaded correctly and wraps from 255 to 0;
- the latched low byte is captured on a high-byte read;
- the control byte is untouched by writes to the identification page.

Only the bench scenarios can show the page contents byte by byte:

- the rules for the read-only, reserved and writable regions;
- the 8-byte user write and the reserved byte just past the user area;
- coherence of a pair read while the sensor port updates in the middle of the transfer;
- the fall-back to the live low byte when it is read on its own.

// File: rtl/diag_tw_pkg.sv
package diag_tw_pkg;
  localparam int PTR_W = 8;

  localparam logic [PTR_W-1:0] ID_TOP     = 8'd127;
  localparam logic [PTR_W-1:0] THR_TOP    = 8'd55;
  localparam logic [PTR_W-1:0] USER_LO    = 8'd128;
  localparam logic [PTR_W-1:0] USER_HI    = 8'd247;
  localparam int               USER_DEPTH = int'(USER_HI) - int'(USER_LO) + 1;
  localparam int               UIDX_W     = $clog2(USER_DEPTH);

  localparam logic [PTR_W-1:0] TEMP_HI  = 8'd96;
  localparam logic [PTR_W-1:0] TEMP_LO  = 8'd97;
  localparam logic [PTR_W-1:0] VCC_HI   = 8'd98;
  localparam logic [PTR_W-1:0] VCC_LO   = 8'd99;
  localparam logic [PTR_W-1:0] CTRL_REG = 8'd110;
  localparam logic [PTR_W-1:0] FLAG_A   = 8'd112;
  localparam logic [PTR_W-1:0] FLAG_B   = 8'd113;
  localparam logic [PTR_W-1:0] FLAG_C   = 8'd116;
  localparam logic [PTR_W-1:0] FLAG_D   = 8'd117;
  localparam int               SOFT_BIT = 6;

  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic             selPage;
    logic             pageDiag;
    logic             setPtr;
    logic             wrByte;
    logic             rdTake;
    logic [7:0]       data;
  } dpStrobe_t;

  function automatic logic [7:0] idPattern(logic [PTR_W-1:0] a);
    return (a <= ID_TOP) ? ({1'b0, a[6:0]} ^ 8'hA5) : 8'h00;
  endfunction

  function automatic logic [7:0] threshPattern(logic [PTR_W-1:0] a);
    return a + 8'h40;
  endfunction
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES < 2) begin : g_single
      logic q;
      always_ff @(posedge clk) begin
        if (!rstN) q <= RESET_VAL;
        else       q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= {STAGES{RESET_VAL}};
        else       pipe <= {pipe[STAGES-2:0], din};
      end
      assign dout = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tw_link_ctrl.sv
module tw_link_ctrl
  import diag_tw_pkg::*;
#(
  parameter logic [6:0] ID_DEV      = 7'h50,
  parameter logic [6:0] DIAG_DEV    = 7'h51,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output dpStrobe_t  strobe,
  output logic       sdaLowOut
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } linkState_t;

  localparam int NLINES = 2;

  logic [NLINES-1:0] rawLines, syncLines;
  assign rawLines = {sdaIn, sclIn};

  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_sync
      tw_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rstN(rstN),
        .din (rawLines[g]),
        .dout(syncLines[g])
      );
    end
  endgenerate

  logic sclS, sdaS, sclPrev, sdaPrev;
  assign sclS = syncLines[0];
  assign sdaS = syncLines[1];

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  linkState_t state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg, txShift;
  logic       rw, firstData, mAck, sdaDrv;

  logic addrHit;
  assign addrHit = (shiftReg[7:1] == ID_DEV) || (shiftReg[7:1] == DIAG_DEV);

  always_comb begin
    strobe          = '0;
    strobe.data     = shiftReg;
    strobe.pageDiag = (shiftReg[7:1] == DIAG_DEV);
    if (sclFall) begin
      unique case (state)
        ST_ADDR:     strobe.selPage = (bitCnt == 4'd8) && addrHit;
        ST_WDATA: begin
          strobe.setPtr = (bitCnt == 4'd8) && firstData;
          strobe.wrByte = (bitCnt == 4'd8) && !firstData;
        end
        ST_ADDR_ACK: strobe.rdTake = rw;
        ST_RACK:     strobe.rdTake = mAck;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      txShift   <= '0;
      rw        <= 1'b0;
      firstData <= 1'b0;
      mAck      <= 1'b0;
      sdaDrv    <= 1'b0;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      if (stopDet) begin
        state  <= ST_IDLE;
        sdaDrv <= 1'b0;
      end else if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaDrv <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (sclRise && bitCnt < 4'd8) begin
              shiftReg <= {shiftReg[6:0], sdaS};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (addrHit) begin
                sdaDrv <= 1'b1;
                rw     <= shiftReg[0];
                state  <= ST_ADDR_ACK;
              end else begin
                state  <= ST_IDLE;
              end
            end
          end
          ST_WDATA: begin
            if (sclRise && bitCnt < 4'd8) begin
              shiftReg <= {shiftReg[6:0], sdaS};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              sdaDrv    <= 1'b1;
              firstData <= 1'b0;
              state     <= ST_WACK;
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (rw) begin
                txShift <= rdData;
                sdaDrv  <= ~rdData[7];
                state   <= ST_RDATA;
              end else begin
                sdaDrv    <= 1'b0;
                firstData <= 1'b1;
                state     <= ST_WDATA;
              end
            end
          end
          ST_WACK: begin
            if (sclFall) begin
              sdaDrv <= 1'b0;
              bitCnt <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaDrv <= 1'b0;
                state  <= ST_RACK;
              end else if (bitCnt != 4'd0) begin
                sdaDrv  <= ~txShift[6];
                txShift <= {txShift[6:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (sclRise) begin
              mAck <= ~sdaS;
            end else if (sclFall) begin
              if (mAck) begin
                bitCnt  <= '0;
                txShift <= rdData;
                sdaDrv  <= ~rdData[7];
                state   <= ST_RDATA;
              end else begin
                state   <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sdaLowOut = sdaDrv;

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaLowOut);

  // R11
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDrv != $past(sdaDrv)) |-> !sclS);

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaLowOut);
endmodule

// File: rtl/diag_page_dp.sv
module diag_page_dp
  import diag_tw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strobe,
  input  logic        sensorLoad,
  input  logic [15:0] tempWord,
  input  logic [15:0] vccWord,
  input  logic [31:0] flagWord,
  output logic [7:0]  rdData,
  output logic        softOff
);
  logic [PTR_W-1:0] ptr;
  logic             pageDiag;
  logic [15:0]      liveTemp, liveVcc;
  logic [31:0]      liveFlags;
  logic [7:0]       tempHold, vccHold;
  logic             tempArm, vccArm;
  logic [7:0]       userMem [USER_DEPTH];

  logic             inUser;
  logic [UIDX_W-1:0] userIdx;
  assign inUser  = (ptr >= USER_LO) && (ptr <= USER_HI);
  assign userIdx = UIDX_W'(ptr - USER_LO);

  always_comb begin
    rdData = 8'h00;
    if (!pageDiag) begin
      rdData = idPattern(ptr);
    end else if (ptr <= THR_TOP) begin
      rdData = threshPattern(ptr);
    end else if (inUser) begin
      rdData = userMem[userIdx];
    end else begin
      unique case (ptr)
        TEMP_HI:  rdData = liveTemp[15:8];
        TEMP_LO:  rdData = tempArm ? tempHold : liveTemp[7:0];
        VCC_HI:   rdData = liveVcc[15:8];
        VCC_LO:   rdData = vccArm ? vccHold : liveVcc[7:0];
        CTRL_REG: rdData = 8'(softOff) << SOFT_BIT;
        FLAG_A:   rdData = liveFlags[31:24];
        FLAG_B:   rdData = liveFlags[23:16];
        FLAG_C:   rdData = liveFlags[15:8];
        FLAG_D:   rdData = liveFlags[7:0];
        default:  rdData = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr       <= '0;
      pageDiag  <= 1'b0;
      liveTemp  <= '0;
      liveVcc   <= '0;
      liveFlags <= '0;
      tempHold  <= '0;
      vccHold   <= '0;
      tempArm   <= 1'b0;
      vccArm    <= 1'b0;
      softOff   <= 1'b0;
      for (int i = 0; i < USER_DEPTH; i++) userMem[i] <= '0;
    end else begin
      if (sensorLoad) begin
        liveTemp  <= tempWord;
        liveVcc   <= vccWord;
        liveFlags <= flagWord;
      end
      if (strobe.selPage) pageDiag <= strobe.pageDiag;
      if (strobe.setPtr) begin
        ptr <= strobe.data;
      end else if (strobe.wrByte) begin
        if (pageDiag && inUser)            userMem[userIdx] <= strobe.data;
        if (pageDiag && ptr == CTRL_REG)   softOff <= strobe.data[SOFT_BIT];
        ptr <= ptr + 1'b1;
      end else if (strobe.rdTake) begin
        tempArm <= pageDiag && (ptr == TEMP_HI);
        vccArm  <= pageDiag && (ptr == VCC_HI);
        if (ptr == TEMP_HI) tempHold <= liveTemp[7:0];
        if (ptr == VCC_HI)  vccHold  <= liveVcc[7:0];
        ptr <= ptr + 1'b1;
      end
    end
  end

  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdTake && ptr == 8'hFF) |=> (ptr == 8'h00));

  // R8
  ptr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setPtr |=> (ptr == $past(strobe.data)));

  // R7
  pair_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdTake && ptr == TEMP_HI) |=> (tempHold == $past(liveTemp[7:0])));

  // R2
  id_readonly_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrByte && !pageDiag) |=> $stable(softOff));
endmodule

// File: rtl/diag_twowire_slave.sv
module diag_twowire_slave
  import diag_tw_pkg::*;
#(
  parameter logic [6:0] ID_DEV      = 7'h50,
  parameter logic [6:0] DIAG_DEV    = 7'h51,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaLowOut,
  input  logic        sensorLoad,
  input  logic [15:0] tempWord,
  input  logic [15:0] vccWord,
  input  logic [31:0] flagWord,
  output logic        ctrlSoftOff
);
  dpStrobe_t  strobe;
  logic [7:0] rdData;

  tw_link_ctrl #(.ID_DEV(ID_DEV), .DIAG_DEV(DIAG_DEV), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .rdData   (rdData),
    .strobe   (strobe),
    .sdaLowOut(sdaLowOut)
  );

  diag_page_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sensorLoad(sensorLoad),
    .tempWord  (tempWord),
    .vccWord   (vccWord),
    .flagWord  (flagWord),
    .rdData    (rdData),
    .softOff   (ctrlSoftOff)
  );
endmodule

// File: tb/diag_twowire_slave_tb.sv
module diag_twowire_slave_tb;
  localparam int HALF = 10;
  localparam logic [6:0] ID_DEV = 7'h50, DIAG_DEV = 7'h51;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, sclM, sdaM, sdaLowOut, sensorLoad, ctrlSoftOff;
  logic [15:0] tempWord, vccWord;
  logic [31:0] flagWord;
  wire  sdaLine = sdaM & ~sdaLowOut;

  diag_twowire_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaLowOut(sdaLowOut),
    .sensorLoad(sensorLoad), .tempWord(tempWord), .vccWord(vccWord),
    .flagWord(flagWord), .ctrlSoftOff(ctrlSoftOff)
  );

  int nCmp = 0, nBad = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] obsByte;
  event       obsEv;
  bit         done = 1'b0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pushExp(input logic [7:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // scoreboard monitor
  initial forever begin
    @(obsEv);
    nCmp++;
    if (expQ.size() == 0) begin
      nBad++;
      $display("FAIL R2 unexpected byte act=%0h exp=none", obsByte);
    end else begin
      automatic logic [7:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      if (obsByte !== e) begin
        nBad++;
        $display("FAIL %s act=%0h exp=%0h", t, obsByte, e);
      end
    end
  end

  task automatic busStart();
    sdaM = 1'b1; tick(HALF);
    sclM = 1'b1; tick(HALF);
    sdaM = 1'b0; tick(HALF);
    sclM = 1'b0; tick(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(HALF);
    sclM = 1'b1; tick(HALF);
    sdaM = 1'b1; tick(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(HALF);
      sclM = 1'b1; tick(HALF);
      sclM = 1'b0; tick(2);
    end
    sdaM = 1'b1; tick(HALF);
    sclM = 1'b1; tick(HALF / 2);
    ack = ~sdaLine;
    tick(HALF / 2);
    sclM = 1'b0; tick(2);
  endtask

  task automatic readByte(input logic ackIt);
    logic [7:0] b;
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      sclM = 1'b1; tick(HALF / 2);
      b[i] = sdaLine;
      tick(HALF / 2);
      sclM = 1'b0;
    end
    tick(2);
    sdaM = ackIt ? 1'b0 : 1'b1; tick(HALF);
    sclM = 1'b1; tick(HALF);
    sclM = 1'b0; tick(2);
    sdaM = 1'b1;
    obsByte = b;
    -> obsEv;
  endtask

  task automatic wrBytes(input logic [6:0] dev, input logic [7:0] p, input int n,
                         input logic [7:0] d [8], input string tag);
    logic a;
    busStart();
    sendByte({dev, 1'b0}, a); check(a, "R1 addr ack", a, 1);
    sendByte(p, a);           check(a, "R8 ptr ack", a, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(d[i], a); check(a, tag, a, 1);
    end
    busStop();
  endtask

  task automatic rdPrefix(input logic [6:0] dev, input logic [7:0] p);
    logic a;
    busStart();
    sendByte({dev, 1'b0}, a); check(a, "R1 addr ack", a, 1);
    sendByte(p, a);           check(a, "R8 ptr ack", a, 1);
    busStart();
    sendByte({dev, 1'b1}, a); check(a, "R1 read addr ack", a, 1);
  endtask

  task automatic rdBytes(input logic [6:0] dev, input logic [7:0] p, input int n);
    rdPrefix(dev, p);
    for (int i = 0; i < n; i++) readByte(i < n - 1);
    busStop();
  endtask

  task automatic loadSensor(input logic [15:0] t, input logic [15:0] v, input logic [31:0] f);
    tempWord = t; vccWord = v; flagWord = f; sensorLoad = 1'b1;
    tick(1);
    sensorLoad = 1'b0;
  endtask

  function automatic logic [7:0] idE(input logic [7:0] a);
    return (a < 8'd128) ? (a ^ 8'hA5) : 8'h00;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog R11 act=hung exp=done");
    finishRun();
  end

  initial begin
    logic a;
    logic [7:0] d [8];
    rstN = 1'b0; sclM = 1'b1; sdaM = 1'b1; sensorLoad = 1'b0;
    tempWord = '0; vccWord = '0; flagWord = '0;
    tick(5);
    rstN = 1'b1;
    tick(5);

    // R12 reset state
    check(sdaLowOut == 1'b0, "R12 line released", sdaLowOut, 0);
    check(ctrlSoftOff == 1'b0, "R12 soft off", ctrlSoftOff, 0);
    pushExp(8'h00, "R12 live temp hi"); pushExp(8'h00, "R12 live temp lo");
    rdBytes(DIAG_DEV, 8'd96, 2);

    // R1 foreign address ignored
    busStart();
    sendByte(8'hA4, a);
    check(a == 1'b0, "R1 foreign nack", a, 0);
    busStop();
    check(sdaLowOut == 1'b0, "R1 idle released", sdaLowOut, 0);

    // R2 identification page
    for (int i = 0; i < 3; i++) pushExp(idE(8'(i)), "R2 id bytes");
    rdBytes(ID_DEV, 8'd0, 3);
    pushExp(idE(8'd127), "R2 id top"); pushExp(8'h00, "R2 id reserved");
    rdBytes(ID_DEV, 8'd127, 2);
    d = '{8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
    wrBytes(ID_DEV, 8'd1, 1, d, "R2 id write ack");
    pushExp(idE(8'd1), "R2 id unchanged");
    rdBytes(ID_DEV, 8'd1, 1);
    d[0] = 8'hFF;
    wrBytes(ID_DEV, 8'd110, 1, d, "R2 id write ack");
    check(ctrlSoftOff == 1'b0, "R2 id write no soft", ctrlSoftOff, 0);

    // R3 thresholds
    d[0] = 8'h00;
    wrBytes(DIAG_DEV, 8'd5, 1, d, "R3 thresh write ack");
    pushExp(8'h45, "R3 thresh kept");
    rdBytes(DIAG_DEV, 8'd5, 1);
    pushExp(8'h77, "R3 thresh top"); pushExp(8'h00, "R4 after thresh");
    rdBytes(DIAG_DEV, 8'd55, 2);

    // R4 reserved
    d[0] = 8'hAA;
    wrBytes(DIAG_DEV, 8'd60, 1, d, "R4 reserved write ack");
    pushExp(8'h00, "R4 reserved 60");
    rdBytes(DIAG_DEV, 8'd60, 1);
    pushExp(8'h00, "R4 reserved 111");
    rdBytes(DIAG_DEV, 8'd111, 1);

    // R5 user area, full 8-byte write
    d = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7};
    wrBytes(DIAG_DEV, 8'd130, 8, d, "R5 user write ack");
    for (int i = 0; i < 8; i++) pushExp(d[i], "R5 user readback");
    rdBytes(DIAG_DEV, 8'd130, 8);
    d = '{8'h5A, 8'hA5, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wrBytes(DIAG_DEV, 8'd246, 3, d, "R5 edge write ack");
    pushExp(8'h5A, "R5 user 246"); pushExp(8'hA5, "R5 user 247"); pushExp(8'h00, "R4 reserved 248");
    rdBytes(DIAG_DEV, 8'd246, 3);

    // R8 wrap
    pushExp(8'h00, "R8 byte 255"); pushExp(8'h40, "R8 wrap to 0");
    rdBytes(DIAG_DEV, 8'd255, 2);

    // R6 live values, R10 flags
    loadSensor(16'h1A2B, 16'h3C4D, 32'h11223344);
    pushExp(8'h1A, "R6 temp hi"); pushExp(8'h2B, "R6 temp lo");
    pushExp(8'h3C, "R6 vcc hi");  pushExp(8'h4D, "R6 vcc lo");
    rdBytes(DIAG_DEV, 8'd96, 4);
    pushExp(8'h11, "R10 flag 112"); pushExp(8'h22, "R10 flag 113");
    pushExp(8'h00, "R4 reserved 114"); pushExp(8'h00, "R4 reserved 115");
    pushExp(8'h33, "R10 flag 116"); pushExp(8'h44, "R10 flag 117");
    rdBytes(DIAG_DEV, 8'd112, 6);

    // R7 coherence with a load in the middle of the high byte
    pushExp(8'h1A, "R7 old hi"); pushExp(8'h2B, "R7 matched lo");
    rdPrefix(DIAG_DEV, 8'd96);
    fork
      readByte(1'b1);
      begin tick(HALF * 4); loadSensor(16'h5E6F, 16'h3C4D, 32'h11223344); end
    join
    readByte(1'b0);
    busStop();
    pushExp(8'h5E, "R7 new hi"); pushExp(8'h6F, "R7 new lo");
    rdBytes(DIAG_DEV, 8'd96, 2);
    loadSensor(16'h7788, 16'h3C4D, 32'h11223344);
    pushExp(8'h88, "R7 lone lo live");
    rdBytes(DIAG_DEV, 8'd97, 1);

    // R9 control byte
    d[0] = 8'hFF;
    wrBytes(DIAG_DEV, 8'd110, 1, d, "R9 ctrl write ack");
    check(ctrlSoftOff == 1'b1, "R9 soft set", ctrlSoftOff, 1);
    pushExp(8'h40, "R9 ctrl readback");
    rdBytes(DIAG_DEV, 8'd110, 1);
    d[0] = 8'h00;
    wrBytes(DIAG_DEV, 8'd110, 1, d, "R9 ctrl write ack");
    check(ctrlSoftOff == 1'b0, "R9 soft clear", ctrlSoftOff, 0);

    // R11 host nack ends the read
    pushExp(8'h40, "R11 read before nack");
    rdPrefix(DIAG_DEV, 8'd0);
    readByte(1'b0);
    tick(HALF);
    check(sdaLowOut == 1'b0, "R11 released after nack", sdaLowOut, 0);
    busStop();
    check(sdaLowOut == 1'b0, "R11 released after stop", sdaLowOut, 0);

    tick(20);
    check(expQ.size() == 0, "R2 scoreboard drained", expQ.size(), 0);
    finishRun();
  end
endmodule